// File: doc/BRIEF.md
# Shared-Medium Collision Backoff and Jam Controller

This block handles what a serial link controller on a shared carrier-sense medium must do once a collision is seen. A one-cycle collision pulse starts a jam phase during which the block takes over the line: it either holds the line low or forwards bits from an external CRC generator, for exactly as many bit times as the CRC is long. Once the jam ends it chooses a backoff slot and counts slot-time ticks. When the slots have been counted it grants one retry. In deterministic mode the slot comes from the station's own slot address. In random mode the slot comes from a free-running pseudo-random register.

A configuration byte selects the jam type and the backoff algorithm and holds the station slot address. The byte is captured whenever a collision is accepted, so software may change it during an episode without disturbing that episode. A station with slot address zero in deterministic mode takes no part in backoff: it releases busy after the jam and never grants a retry. All pins are plain control and status levels or pulses. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. Jam bits are consumed only on bit-clock enable cycles.

Top module: `csmacd_backoff`

## Requirements
- R1: After reset, busy_o, retry_o and jam_sel_o are all low.
- R2: A collision pulse (coll_i high) while idle is accepted. From the next cycle, busy_o and jam_sel_o are high. The configuration byte is captured at each accepted collision.
- R3: The jam phase lasts exactly CRC_LEN cycles in which bit_en_i is high. Cycles without bit_en_i are not counted. jam_sel_o falls after the edge that consumes the last enable.
- R4: While jam_sel_o is high, jam_bit_o is 0 if captured bit 7 is 1. It equals crc_bit_i if captured bit 7 is 0.
- R5: If captured bit 6 is 1 (deterministic mode) and the address in bits 5..0 is nonzero, the backoff phase lasts that many slot_tick_i pulses. retry_o is high in the cycle after the edge that consumes the last tick, and busy_o is low in that same cycle.
- R6: In deterministic mode with address 0, busy_o falls right after the jam and retry_o stays low.
- R7: If captured bit 6 is 0 (random mode), the slot count is bits 5..0 of the 16-bit shift register, taken at the edge that ends the jam. A value of 0 is replaced by 1.
- R8: The shift register loads 0xACE1 at reset and shifts left every clock. The new bit 0 is the XOR of bits 15, 13, 12 and 10. The register never holds all zeros.
- R9: A collision pulse during the jam phase is ignored: the jam length is unchanged.
- R10: A collision pulse during backoff restarts a full jam, even if a slot tick arrives in the same cycle. That tick is not counted.
- R11: retry_o is a single-cycle pulse. Slot ticks outside the backoff phase are not counted.
- R12: Changes to cfg_i after a collision has been accepted have no effect on that episode's jam type, algorithm or slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 8 | Bit 7 jam type, bit 6 algorithm, bits 5..0 slot address |
| coll_i | input | 1 | Collision pulse |
| bit_en_i | input | 1 | Bit-clock enable |
| crc_bit_i | input | 1 | Current bit from the external CRC generator |
| slot_tick_i | input | 1 | One pulse per slot time |
| jam_sel_o | output | 1 | High while the jam owns the line |
| jam_bit_o | output | 1 | Line value during the jam |
| retry_o | output | 1 | One-cycle retry grant |
| busy_o | output | 1 | High from an accepted collision until retry or release |

## Verification
The bench builds the block with CRC_LEN = 16, the default seed and the default taps. This keeps each jam short enough for many episodes to fit in one run, including irregular bit-enable gaps. The bench carries its own model of the shift register from the seed and tap rule. This lets it predict random slot counts exactly, across several episodes started at different register phases. With a 6-bit address, deterministic runs can reach both address 63 and address 0.

// File: rtl/backoff_pkg.sv
package backoff_pkg;
  localparam int SLOT_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_JAM     = 2'd1,
    ST_BACKOFF = 2'd2
  } bo_state_e;

  typedef struct packed {
    logic              jam_low;
    logic              det;
    logic [SLOT_W-1:0] addr;
  } bo_cfg_t;
endpackage

// File: rtl/bo_lfsr.sv
module bo_lfsr #(
  parameter int          W     = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter int          OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] low_o
);
  logic [W-1:0] q;
  logic         fb;

  assign fb    = ^(q & TAPS);
  assign low_o = q[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= SEED;
    else if (q == '0)    q <= SEED;
    else                 q <= {q[W-2:0], fb};
  end

  p_lfsr_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n) q != '0);
endmodule

// File: rtl/bo_jam_ctr.sv
module bo_jam_ctr #(
  parameter int CRC_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic active_i,
  input  logic bit_en_i,
  output logic done_o
);
  localparam int CW = $clog2(CRC_LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cnt_q <= '0;
    else if (start_i)                            cnt_q <= CW'(CRC_LEN);
    else if (active_i && bit_en_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = active_i && bit_en_i && (cnt_q == CW'(1));

  p_jam_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !bit_en_i && !start_i) |=> $stable(cnt_q));
  p_jam_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> cnt_q != '0);
endmodule

// File: rtl/bo_slot_pick.sv
module bo_slot_pick
  import backoff_pkg::*;
(
  input  logic              det_i,
  input  logic [SLOT_W-1:0] addr_i,
  input  logic [SLOT_W-1:0] rnd_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              skip_o
);
  always_comb begin
    skip_o = 1'b0;
    if (det_i) begin
      slot_o = addr_i;
      skip_o = (addr_i == '0);
    end else if (rnd_i == '0) begin
      slot_o = SLOT_W'(1);
    end else begin
      slot_o = rnd_i;
    end
  end
endmodule

// File: rtl/bo_slot_ctr.sv
module bo_slot_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         active_i,
  input  logic         tick_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt_q <= '0;
    else if (load_i)                           cnt_q <= load_val_i;
    else if (active_i && tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = active_i && tick_i && (cnt_q == W'(1));

  p_slot_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/csmacd_backoff.sv
module csmacd_backoff
  import backoff_pkg::*;
#(
  parameter int               CRC_LEN   = 16,
  parameter int               LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg_i,
  input  logic       coll_i,
  input  logic       bit_en_i,
  input  logic       crc_bit_i,
  input  logic       slot_tick_i,
  output logic       jam_sel_o,
  output logic       jam_bit_o,
  output logic       retry_o,
  output logic       busy_o
);
  bo_state_e         state_q, state_d;
  bo_cfg_t           cfg_q;
  logic              retry_q;
  logic              coll_take, jam_done, slot_done, skip, slot_active;
  logic [SLOT_W-1:0] rnd_low, slot_val;

  assign coll_take   = coll_i && (state_q == ST_IDLE || state_q == ST_BACKOFF);
  assign slot_active = (state_q == ST_BACKOFF) && !coll_i;

  bo_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED), .OUT_W(SLOT_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .low_o(rnd_low));

  bo_jam_ctr #(.CRC_LEN(CRC_LEN)) u_jam (
    .clk(clk), .rst_n(rst_n), .start_i(coll_take),
    .active_i(state_q == ST_JAM), .bit_en_i(bit_en_i), .done_o(jam_done));

  bo_slot_pick u_pick (
    .det_i(cfg_q.det), .addr_i(cfg_q.addr), .rnd_i(rnd_low),
    .slot_o(slot_val), .skip_o(skip));

  bo_slot_ctr #(.W(SLOT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load_i(jam_done && !skip), .load_val_i(slot_val),
    .active_i(slot_active), .tick_i(slot_tick_i), .done_o(slot_done));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (coll_i) state_d = ST_JAM;
      ST_JAM:     if (jam_done) state_d = skip ? ST_IDLE : ST_BACKOFF;
      ST_BACKOFF: begin
        if (coll_i)         state_d = ST_JAM;
        else if (slot_done) state_d = ST_IDLE;
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      retry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      retry_q <= slot_done;
      if (coll_take) cfg_q <= bo_cfg_t'(cfg_i);
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign jam_sel_o = (state_q == ST_JAM);
  assign jam_bit_o = cfg_q.jam_low ? 1'b0 : crc_bit_i;
  assign retry_o   = retry_q;

  p_coll_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && coll_i) |=> (busy_o && jam_sel_o));
  p_coll_in_jam_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (jam_sel_o && coll_i && !jam_done) |=> jam_sel_o);
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !jam_sel_o && coll_i) |=> (jam_sel_o && !retry_o));
  p_retry_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |-> !busy_o);
  p_retry_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |=> !retry_o);
  p_slot_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (jam_done && !skip) |-> slot_val != '0);
  p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !coll_take) |=> $stable(cfg_q));
endmodule

// File: tb/sim_csmacd_backoff.sv
module sim_csmacd_backoff;
  localparam int CLK_NS = 10;
  localparam int CRC    = 16;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam logic [15:0] TAPS = 16'hB400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_i = 8'h00;
  logic       coll_i = 1'b0, bit_en_i = 1'b0, crc_bit_i = 1'b0, slot_tick_i = 1'b0;
  logic       jam_sel_o, jam_bit_o, retry_o, busy_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct { int jam_bits; int ticks; bit retry; } ep_t;
  ep_t exp_q[$];

  always #(CLK_NS/2) clk = ~clk;

  csmacd_backoff #(.CRC_LEN(CRC), .LFSR_TAPS(TAPS), .LFSR_SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .coll_i(coll_i), .bit_en_i(bit_en_i),
    .crc_bit_i(crc_bit_i), .slot_tick_i(slot_tick_i), .jam_sel_o(jam_sel_o),
    .jam_bit_o(jam_bit_o), .retry_o(retry_o), .busy_o(busy_o));

  // Model of the shift register from R8
  logic [15:0] m_lfsr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_lfsr <= SEED;
    else        m_lfsr <= {m_lfsr[14:0], ^(m_lfsr & TAPS)};
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // Monitor: measures each episode at the ports and compares with the queue
  initial begin
    int  jb = 0, tk = 0;
    bit  pb = 1'b0, want_low = 1'b0;
    ep_t e;
    forever begin
      @(negedge clk);
      #(CLK_NS/4);
      if (!rst_n) begin
        jb = 0; tk = 0; pb = 1'b0; want_low = 1'b0;
      end else begin
        if (want_low) begin
          check(retry_o == 1'b0, "R11 retry width", retry_o, 0);
          want_low = 1'b0;
        end
        if (busy_o && !pb) begin jb = 0; tk = 0; end
        if (jam_sel_o && bit_en_i) jb++;
        if (busy_o && !jam_sel_o && coll_i) begin jb = 0; tk = 0; end
        else if (busy_o && !jam_sel_o && slot_tick_i) tk++;
        if (!busy_o && pb) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected episode", 1, 0);
          end else begin
            e = exp_q.pop_front();
            check(jb == e.jam_bits, "R3 jam length", jb, e.jam_bits);
            check(tk == e.ticks, "R5/R7 slot count", tk, e.ticks);
            check(retry_o == e.retry, "R5/R6 retry at release", retry_o, e.retry);
            if (retry_o) want_low = 1'b1;
          end
        end
        pb = busy_o;
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      coll_i = 0; bit_en_i = 0; slot_tick_i = (i % 3 == 1);
    end
  endtask

  // Jam phase: returns the shift register value used at the jam-ending edge
  task automatic do_jam(input logic [7:0] cap, input bit gaps, input bit coll_mid,
                        input bit chg, output logic [15:0] lf);
    for (int i = 0; i < CRC; i++) begin
      if (gaps && (i % 4 == 2)) begin
        @(negedge clk);
        coll_i = 0; bit_en_i = 0; slot_tick_i = 1; crc_bit_i = 1;
      end
      @(negedge clk);
      coll_i      = coll_mid && (i == CRC/2);
      bit_en_i    = 1;
      slot_tick_i = (i % 2 == 0);
      crc_bit_i   = ((i * 5 + 3) % 7) > 2;
      if (chg && i == 3) cfg_i = ~cap;
      if (i == CRC-1) lf = m_lfsr;
      #1;
      check(jam_sel_o == 1'b1, "R3 jam active", jam_sel_o, 1);
      if (i == 0 || i == CRC-1 || i == CRC/2)
        check(jam_bit_o == (cap[7] ? 1'b0 : crc_bit_i), "R4 jam bit",
              jam_bit_o, cap[7] ? 0 : crc_bit_i);
    end
    @(negedge clk);
    coll_i = 0; bit_en_i = 0; slot_tick_i = 0;
  endtask

  task automatic episode(input logic [7:0] cfg, input bit gaps, input bit coll_mid,
                         input bit chg, input int restart_at);
    logic [15:0] lf;
    int slots;
    bit skip;
    @(negedge clk);
    cfg_i = cfg; coll_i = 1; bit_en_i = 0; slot_tick_i = 1;
    #1 check(busy_o == 1'b0, "R2 idle before collision", busy_o, 0);
    @(negedge clk);
    coll_i = 0; slot_tick_i = 0;
    #1 check(busy_o && jam_sel_o, "R2 busy after collision", busy_o, 1);
    do_jam(cfg, gaps, coll_mid, chg, lf);
    skip  = cfg[6] && cfg[5:0] == 0;
    slots = cfg[6] ? int'(cfg[5:0]) : (lf[5:0] == 0 ? 1 : int'(lf[5:0]));
    if (restart_at >= 0) begin
      for (int s = 0; s < restart_at; s++) begin
        slot_tick_i = 1; @(negedge clk); slot_tick_i = 0;
      end
      coll_i = 1; slot_tick_i = 1;
      @(negedge clk);
      coll_i = 0; slot_tick_i = 0;
      #1 check(jam_sel_o == 1'b1, "R10 restart jam", jam_sel_o, 1);
      do_jam(cfg, 1'b0, 1'b0, 1'b0, lf);
      slots = cfg[6] ? int'(cfg[5:0]) : (lf[5:0] == 0 ? 1 : int'(lf[5:0]));
    end
    exp_q.push_back('{CRC, skip ? 0 : slots, !skip});
    if (skip) begin
      #1 check(busy_o == 1'b0, "R6 release without retry", busy_o, 0);
      for (int k = 0; k < 5; k++) begin
        @(negedge clk); slot_tick_i = 1;
        #1 check(retry_o == 1'b0, "R6 no retry", retry_o, 0);
      end
      slot_tick_i = 0;
    end else begin
      for (int s = 0; s < slots; s++) begin
        if (gaps && s % 2 == 1) begin
          slot_tick_i = 0; @(negedge clk);
        end
        slot_tick_i = 1;
        #1 check(retry_o == 1'b0 && busy_o, "R5 waiting", retry_o, 0);
        @(negedge clk);
        slot_tick_i = 0;
      end
      #1 check(retry_o == 1'b1 && !busy_o, cfg[6] ? "R5 retry" : "R7 retry", retry_o, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(busy_o == 0, "R1 busy reset", busy_o, 0);
    check(retry_o == 0, "R1 retry reset", retry_o, 0);
    check(jam_sel_o == 0, "R1 jam_sel reset", jam_sel_o, 0);
    @(negedge clk);
    rst_n = 1;
    idle(3);
    episode(8'h45, 1'b1, 1'b0, 1'b0, -1);   // R5 deterministic, CRC jam, gaps
    idle(4);
    episode(8'hC3, 1'b0, 1'b0, 1'b0, -1);   // R4 low jam
    idle(2);
    episode(8'hC0, 1'b0, 1'b0, 1'b0, -1);   // R6 address zero
    idle(3);
    episode(8'h7F, 1'b0, 1'b0, 1'b0, -1);   // R5 address 63
    idle(2);
    episode(8'h42, 1'b0, 1'b1, 1'b0, -1);   // R9 collision inside jam
    idle(2);
    episode(8'h46, 1'b0, 1'b0, 1'b0, 2);    // R10 restart from backoff
    idle(2);
    episode(8'hC3, 1'b0, 1'b0, 1'b1, -1);   // R12 config change ignored
    for (int r = 0; r < 6; r++) begin       // R7 random mode, R8 sequence
      idle(1 + r * 7);
      episode(r % 2 ? 8'h80 : 8'h15, r % 2 == 1, 1'b0, 1'b0, -1);
    end
    idle(2);
    episode(8'h00, 1'b0, 1'b0, 1'b0, 1);    // R10 restart in random mode
    idle(6);
    check(exp_q.size() == 0, "R5 all episodes seen", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule